// File: doc/BRIEF.md
# Edge-Tracking Bit Synchronizer

This block recovers bit timing from a serial line sampled by a fast local clock. It keeps a fixed-point phase that counts the time since the bit boundary it last predicted. Each transition on the line is treated as a measurement of where the boundary really lies. The distance from the prediction is folded into a half-period window on either side of it, scaled down by a selectable power of two, and removed from the phase. Between transitions the phase simply advances one tick per clock, so the tracker coasts at the nominal period.

Halfway through each predicted bit the block raises a one-cycle strobe and presents the synchronized line value as the recovered bit. A lock flag reports whether recent edges have landed close to their predictions. The nominal period, in clock ticks, and the gain setting are plain inputs. They are expected to change only while the block is held in reset.

Top module: `bitsync_top`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `strobe_o`, `bit_o` and `lock_o` are 0.
- R2: `din_i` passes through two flip-flops before use. An edge is flagged when the second stage differs from a third, delayed copy of it. The recovered data value is the second-stage output.
- R3: The phase is held in units of 1/16 tick, so a period P equals `period_i`*16. On an edge, the phase error is the phase t when t < P/2, and t − P otherwise.
- R4: On an edge, the phase becomes phase + 16 − (error arithmetically shifted right by `gain_i`+1), where `gain_i` is 0..3. The result is wrapped once into [0, P).
- R5: With no edge, the phase advances by exactly 16 per cycle modulo P, so strobes come every `period_i` cycles.
- R6: `strobe_o` pulses for one cycle, one clock after the cycle in which the unwrapped next phase crosses P/2 from below without reaching P.
- R7: `bit_o` takes the synchronized data value in the cycle the strobe is raised. It holds that value while the strobe is low.
- R8: `lock_o` rises after 8 consecutive edges whose error magnitude is at most P/8. An edge outside that bound restarts the count.
- R9: While locked, 4 consecutive edges with error magnitude above P/4 clear `lock_o`. Any other edge restarts that count.
- R10: The phase always stays in the range 0 to P−1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din_i | input | 1 | Asynchronous serial line |
| period_i | input | PW (7) | Nominal bit period in clock ticks |
| gain_i | input | 2 | Error shift select, shift = value + 1 |
| strobe_o | output | 1 | One-cycle pulse at the bit centre |
| bit_o | output | 1 | Recovered bit, valid with the strobe |
| lock_o | output | 1 | Timing lock indicator |

## Verification
The assertions check on every cycle that the phase stays inside one period, that the strobe never lasts two cycles, and that the recovered bit moves only with a strobe. They also check that the lock flag changes only in the cycle after an edge. Only the bench scenarios can show the arithmetic itself: folding of the error, the shifted correction, and the exact centre timing. The same holds for lock gained on a clean preamble, lock lost after a half-period phase jump, tracking of a transmitter running 3% slow with random data, and strobe spacing while the line is idle. The bench shows these by comparing the block against a behavioural model on every clock.

// File: rtl/bitsync_pkg.sv
package bitsync_pkg;

  localparam int FRAC = 4;

  // fold a phase into [-P/2, P/2)
  function automatic logic signed [31:0] fold_err(input logic signed [31:0] ph,
                                                  input logic signed [31:0] p);
    return (ph >= (p >>> 1)) ? ph - p : ph;
  endfunction

  // fractional gain as arithmetic shift by sel+1
  function automatic logic signed [31:0] scale_err(input logic signed [31:0] e,
                                                   input logic [1:0] sel);
    return e >>> ({1'b0, sel} + 3'd1);
  endfunction

  function automatic logic signed [31:0] abs_err(input logic signed [31:0] e);
    return (e < 0) ? -e : e;
  endfunction

  function automatic logic within_eighth(input logic signed [31:0] e,
                                         input logic signed [31:0] p);
    return abs_err(e) <= (p >>> 3);
  endfunction

  function automatic logic beyond_quarter(input logic signed [31:0] e,
                                          input logic signed [31:0] p);
    return abs_err(e) > (p >>> 2);
  endfunction

endpackage

// File: rtl/bitsync_inq.sv
module bitsync_inq (
  input  logic clk,
  input  logic rst_n,
  input  logic din_i,
  output logic edge_o,
  output logic data_o
);
  logic [2:0] stg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= {stg_q[1:0], din_i};
  end

  assign data_o = stg_q[1];
  assign edge_o = stg_q[1] ^ stg_q[2];
endmodule

// File: rtl/bitsync_phase.sv
module bitsync_phase
  import bitsync_pkg::*;
#(
  parameter int PW = 7
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         edge_i,
  input  logic [PW-1:0]                period_i,
  input  logic [1:0]                   gain_i,
  output logic signed [PW+FRAC+1:0]    ph_o,
  output logic signed [PW+FRAC+1:0]    err_o,
  output logic signed [PW+FRAC+1:0]    pfix_o,
  output logic                         cross_o
);
  localparam int AW = PW + FRAC + 2;
  localparam logic signed [AW-1:0] ONE = AW'(2 ** FRAC);

  logic signed [AW-1:0] ph_q, pfix, half, err, corr, raw, nxt;

  always_comb begin
    pfix = $signed({2'b00, period_i, {FRAC{1'b0}}});
    half = pfix >>> 1;
    err  = AW'(fold_err(32'(ph_q), 32'(pfix)));
    corr = edge_i ? AW'(scale_err(32'(err), gain_i)) : '0;
    raw  = ph_q + ONE - corr;
    if (raw >= pfix)   nxt = raw - pfix;
    else if (raw < 0)  nxt = raw + pfix;
    else               nxt = raw;
    cross_o = (ph_q < half) && (raw >= half) && (raw < pfix);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= nxt;
  end

  assign ph_o   = ph_q;
  assign err_o  = err;
  assign pfix_o = pfix;
endmodule

// File: rtl/bitsync_lock.sv
module bitsync_lock
  import bitsync_pkg::*;
#(
  parameter int AW       = 13,
  parameter int LOCK_N   = 8,
  parameter int UNLOCK_N = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 edge_i,
  input  logic signed [AW-1:0] err_i,
  input  logic signed [AW-1:0] pfix_i,
  output logic                 lock_o
);
  localparam int GW = $clog2(LOCK_N + 1);
  localparam int BW = $clog2(UNLOCK_N + 1);

  logic [GW-1:0] good_q;
  logic [BW-1:0] bad_q;
  logic          lock_q, tight, loose;

  always_comb begin
    tight = within_eighth(32'(err_i), 32'(pfix_i));
    loose = beyond_quarter(32'(err_i), 32'(pfix_i));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      good_q <= '0;
      bad_q  <= '0;
      lock_q <= 1'b0;
    end else if (edge_i) begin
      if (!lock_q) begin
        if (!tight)                              good_q <= '0;
        else if (good_q == GW'(LOCK_N - 1)) begin
          lock_q <= 1'b1;
          good_q <= '0;
          bad_q  <= '0;
        end else                                 good_q <= good_q + 1'b1;
      end else begin
        if (!loose)                              bad_q <= '0;
        else if (bad_q == BW'(UNLOCK_N - 1)) begin
          lock_q <= 1'b0;
          bad_q  <= '0;
          good_q <= '0;
        end else                                 bad_q <= bad_q + 1'b1;
      end
    end
  end

  assign lock_o = lock_q;
endmodule

// File: rtl/bitsync_top.sv
module bitsync_top
  import bitsync_pkg::*;
#(
  parameter int OSR      = 16,
  parameter int PW       = $clog2(OSR) + 3,
  parameter int LOCK_N   = 8,
  parameter int UNLOCK_N = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          din_i,
  input  logic [PW-1:0] period_i,
  input  logic [1:0]    gain_i,
  output logic          strobe_o,
  output logic          bit_o,
  output logic          lock_o
);
  localparam int AW = PW + FRAC + 2;

  logic                 edge_w, data_w, cross_w;
  logic signed [AW-1:0] ph_w, err_w, pfix_w;
  logic                 strobe_q, bit_q;

  bitsync_inq u_inq (
    .clk    (clk),
    .rst_n  (rst_n),
    .din_i  (din_i),
    .edge_o (edge_w),
    .data_o (data_w)
  );

  bitsync_phase #(.PW(PW)) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .edge_i   (edge_w),
    .period_i (period_i),
    .gain_i   (gain_i),
    .ph_o     (ph_w),
    .err_o    (err_w),
    .pfix_o   (pfix_w),
    .cross_o  (cross_w)
  );

  bitsync_lock #(.AW(AW), .LOCK_N(LOCK_N), .UNLOCK_N(UNLOCK_N)) u_lock (
    .clk    (clk),
    .rst_n  (rst_n),
    .edge_i (edge_w),
    .err_i  (err_w),
    .pfix_i (pfix_w),
    .lock_o (lock_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      bit_q    <= 1'b0;
    end else begin
      strobe_q <= cross_w;
      if (cross_w) bit_q <= data_w;
    end
  end

  assign strobe_o = strobe_q;
  assign bit_o    = bit_q;
endmodule

// File: rtl/bitsync_chk.sv
module bitsync_chk #(
  parameter int AW = 13
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 strobe_o,
  input logic                 bit_o,
  input logic                 lock_o,
  input logic                 edge_w,
  input logic signed [AW-1:0] ph_w,
  input logic signed [AW-1:0] pfix_w
);
  // R6
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |=> !strobe_o);

  // R7
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_o |-> $stable(bit_o));

  // R10
  phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_w >= 0) && (ph_w < pfix_w));

  // R8
  lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_o) |-> $past(edge_w));

  // R9
  lock_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_o) |-> $past(edge_w));
endmodule

bind bitsync_top bitsync_chk #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .strobe_o (strobe_o),
  .bit_o    (bit_o),
  .lock_o   (lock_o),
  .edge_w   (edge_w),
  .ph_w     (ph_w),
  .pfix_w   (pfix_w)
);

// File: tb/bitsync_top_bench.sv
module bitsync_top_bench;
  localparam int PW = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          din_i = 1'b0;
  logic [PW-1:0] period_i = 7'd16;
  logic [1:0]    gain_i = 2'd0;
  logic          strobe_o, bit_o, lock_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  bitsync_top u_bitsync_top (
    .clk(clk), .rst_n(rst_n), .din_i(din_i), .period_i(period_i),
    .gain_i(gain_i), .strobe_o(strobe_o), .bit_o(bit_o), .lock_o(lock_o)
  );

  always #5 clk = ~clk;

  // behavioural reference state
  int syncq[$] = '{0, 0, 0};
  int m_ph = 0, m_gc = 0, m_bc = 0;
  int m_strobe = 0, m_bit = 0, m_lock = 0;
  int strobe_cyc[$];

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      syncq = '{0, 0, 0};
      m_ph = 0; m_gc = 0; m_bc = 0;
      m_strobe = 0; m_bit = 0; m_lock = 0;
    end else begin
      int p, h, e, err, corr, raw, am;
      p = int'(period_i) * 16;
      h = p / 2;
      e = (syncq[1] != syncq[2]);
      err = (m_ph >= h) ? m_ph - p : m_ph;
      corr = e ? (err >>> (int'(gain_i) + 1)) : 0;
      raw = m_ph + 16 - corr;
      m_strobe = (m_ph < h && raw >= h && raw < p);
      if (m_strobe) m_bit = syncq[1];
      m_ph = (raw >= p) ? raw - p : (raw < 0) ? raw + p : raw;
      am = (err < 0) ? -err : err;
      if (e) begin
        if (!m_lock) begin
          if (am * 8 <= p) begin
            m_gc++;
            if (m_gc == 8) begin m_lock = 1; m_gc = 0; m_bc = 0; end
          end else m_gc = 0;
        end else begin
          if (am * 4 > p) begin
            m_bc++;
            if (m_bc == 4) begin m_lock = 0; m_bc = 0; m_gc = 0; end
          end else m_bc = 0;
        end
      end
      void'(syncq.pop_back());
      syncq.push_front(int'(din_i));
    end
  end

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", what, act, exp, cyc);
    end
  endtask

  // cycle compare, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check(int'(strobe_o) == m_strobe, "R2 R3 R4 R6 R10 strobe", strobe_o, m_strobe);
      check(int'(bit_o) == m_bit, "R2 R7 bit", bit_o, m_bit);
      check(int'(lock_o) == m_lock, "R8 R9 lock", lock_o, m_lock);
      if (strobe_o) strobe_cyc.push_back(cyc);
    end
  end

  // transmitter
  int tx_t = 0, last_idx = -1;
  int lfsr = 16'hACE1;

  task automatic send(input int nbits, input int per_fix, input int mode);
    int sent = 0;
    while (sent < nbits) begin
      @(negedge clk);
      tx_t += 16;
      if (tx_t / per_fix != last_idx) begin
        last_idx = tx_t / per_fix;
        sent++;
        if (mode == 0) din_i = ~din_i;
        else begin
          din_i = lfsr[0];
          lfsr = (lfsr >> 1) ^ (lfsr[0] ? 16'hB400 : 16'h0000);
        end
      end
    end
  endtask

  task automatic do_reset(input int per, input int g);
    @(negedge clk);
    rst_n = 1'b0;
    period_i = PW'(per);
    gain_i = 2'(g);
    repeat (4) @(negedge clk);
    // R1
    check(strobe_o == 1'b0 && bit_o == 1'b0 && lock_o == 1'b0, "R1 reset outputs",
          {strobe_o, bit_o, lock_o}, 0);
    rst_n = 1'b1;
    tx_t = 0; last_idx = -1;
  endtask

  initial begin : watchdog
    #1500000;
    errors++;
    checks++;
    $display("FAIL watchdog expired: actual %0d expected %0d", cyc, 150000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset(16, 0);
    @(negedge clk);
    check(strobe_o == 1'b0 && lock_o == 1'b0, "R1 first cycle", {strobe_o, lock_o}, 0);

    // clean alternating preamble at the nominal period
    send(40, 256, 0);
    check(lock_o == 1'b1, "R8 lock on preamble", lock_o, 1);

    // half-period phase jump with the smallest gain
    gain_i = 2'd3;
    tx_t += 128;
    send(12, 256, 0);
    check(lock_o == 1'b0, "R9 lock lost after jump", lock_o, 0);

    // random data from a slow transmitter
    gain_i = 2'd1;
    send(300, 264, 1);

    // idle line: free run
    repeat (40) @(negedge clk);
    strobe_cyc.delete();
    repeat (200) @(negedge clk);
    check(strobe_cyc.size() >= 11, "R5 idle strobe count", strobe_cyc.size(), 12);
    for (int i = 1; i < strobe_cyc.size(); i++)
      check(strobe_cyc[i] - strobe_cyc[i-1] == 16, "R5 R6 idle spacing",
            strobe_cyc[i] - strobe_cyc[i-1], 16);

    // shorter period, slightly fast transmitter
    do_reset(12, 2);
    send(60, 190, 0);
    check(lock_o == 1'b1, "R8 lock at period 12", lock_o, 1);
    send(80, 190, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule